// File: doc/BRIEF.md
# Configurable Two-Level AND-OR Logic Array

This block models a field-configurable sum-of-products array. Twelve dedicated inputs and ten bidirectional pin levels form a 22-signal bus, and every product term in the AND plane may use either polarity of any of these signals. Thirty-two logic terms feed an OR plane with ten outputs, and each output has its own polarity stage. Ten further product terms, one for each bidirectional pin, drive that pin's output enable.

All connection links are held in configuration registers. These registers are loaded one row at a time through an addressed write port. The evaluation path from inputs to outputs has no registers at all. The tri-state pad is not part of this block. The block produces a separate output value and output enable for each pin. It reads back the resolved pad level on `pin_in`, which is the driven value when the pin is enabled and the external level when it is not, so pin feedback closes through the pad outside the block. On reset every link returns to its intact state. In that state every term is inhibited, every term is connected to every OR, and every output is active-high.

Top module: `cfg_logic_array`

## Requirements
- R1: After reset and before any write to a mapped address, `pin_oe` is all zeros and `pin_out` is all zeros, whatever the inputs are.
- R2: Each signal in an AND row has a link pair. Bit 2i is the true link and bit 2i+1 is the complement link, and 1 means intact. Pair 01 uses signal i, pair 10 uses its inverse, pair 00 ignores the signal, and pair 11 forces the whole term to 0.
- R3: The 22 AND-plane signals are `din[11:0]` at indices 0 to 11 and `pin_in[9:0]` at indices 12 to 21. A pin that is driven by the block therefore feeds its own output value back into the array through the pad.
- R4: Bit j of OR row k connects logic term j to output k. Every connected term is ORed into the output, and an unconnected term contributes 0.
- R5: Polarity bit k set to 1 makes `pin_out[k]` the sum of products. Set to 0, it makes `pin_out[k]` the inverse of the sum of products.
- R6: `pin_oe[k]` equals control term k, so a term that evaluates to 0, including one with an inhibiting pair, leaves pin k undriven.
- R7: The write address map is as follows. Rows 0 to 31 are the logic terms. Rows 32 to 41 are the control terms for pins 0 to 9. Rows 42 to 51 are the OR rows for outputs 0 to 9. Row 52 is the polarity word. A write to addresses 53 to 63, and any cycle with `cfg_we` low, leaves every link unchanged.
- R8: Outputs follow changes on `din` and `pin_in` within the same cycle, without any clock edge.
- R9: A write is captured at the rising clock edge. Outputs show the old configuration before that edge and the new one after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration register clock |
| rst | input | 1 | Synchronous active-high reset to the all-intact state |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | 6 | Row address |
| cfg_wdata | input | 44 | Row data, right aligned |
| din | input | 12 | Dedicated inputs |
| pin_in | input | 10 | Resolved pad levels of the bidirectional pins |
| pin_out | output | 10 | Output value per pin after polarity |
| pin_oe | output | 10 | Output enable per pin from the control terms |

## Verification
On every clock, the assertions check four things. Outputs stay at the virgin idle value until the first mapped write. An inhibiting pair in a control row keeps that pin's enable low. An OR row with no connections shows only the polarity level. Unmapped writes and idle cycles leave the link state and outputs steady. Only the bench's scenarios can show that each link-pair code selects the right literal, and that ORing, polarity and the control terms give the correct Boolean results. The same scenarios show that a driven pin's value returns through the pad into another term, and that random configurations match an independent model in both the all-output and the mixed-direction setups.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // Literal produced by one link pair {complement, true} for signal s.
   // 01 -> s, 10 -> ~s, 00 -> no condition, 11 -> kills the term.
   function automatic logic link_lit(input logic [1:0] pr, input logic s);
      case (pr)
         2'b01:   return s;
         2'b10:   return ~s;
         2'b00:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int cla_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/cla_cfg_store.sv
module cla_cfg_store #(
   parameter int N_ATERM = 42,
   parameter int N_LTERM = 32,
   parameter int N_OUT   = 10,
   parameter int ROW_W   = 44,
   parameter int AW      = 6,
   parameter int DW      = 44
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [DW-1:0]              wr_data,
   output logic [N_ATERM*ROW_W-1:0]   and_links,
   output logic [N_OUT*N_LTERM-1:0]   or_links,
   output logic [N_OUT-1:0]           pol_bits
);
   localparam int OR_BASE  = N_ATERM;
   localparam int POL_ADDR = N_ATERM + N_OUT;

   if (DW < ROW_W || DW < N_LTERM || DW < N_OUT) begin : g_bad_dw
      $error("cla_cfg_store: write data narrower than a row");
   end

   logic [ROW_W-1:0]   and_q [N_ATERM];
   logic [N_LTERM-1:0] or_q  [N_OUT];
   logic [N_OUT-1:0]   pol_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < N_ATERM; r++) and_q[r] <= '1;
         for (int k = 0; k < N_OUT; k++)   or_q[k]  <= '1;
         pol_q <= '1;
      end else if (wr_en) begin
         for (int r = 0; r < N_ATERM; r++)
            if (wr_addr == AW'(r)) and_q[r] <= wr_data[ROW_W-1:0];
         for (int k = 0; k < N_OUT; k++)
            if (wr_addr == AW'(OR_BASE + k)) or_q[k] <= wr_data[N_LTERM-1:0];
         if (wr_addr == AW'(POL_ADDR)) pol_q <= wr_data[N_OUT-1:0];
      end
   end

   for (genvar r = 0; r < N_ATERM; r++) begin : g_and_flat
      assign and_links[r*ROW_W +: ROW_W] = and_q[r];
   end
   for (genvar k = 0; k < N_OUT; k++) begin : g_or_flat
      assign or_links[k*N_LTERM +: N_LTERM] = or_q[k];
   end
   assign pol_bits = pol_q;

endmodule

// File: rtl/cla_and_plane.sv
module cla_and_plane #(
   parameter int N_TERM = 32,
   parameter int N_SIG  = 22
) (
   input  logic [N_SIG-1:0]          sig,
   input  logic [N_TERM*2*N_SIG-1:0] links,
   output logic [N_TERM-1:0]         term
);
   localparam int ROW_W = 2 * N_SIG;

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_SIG-1:0] lit;
      for (genvar i = 0; i < N_SIG; i++) begin : g_lit
         assign lit[i] = cla_pkg::link_lit(links[t*ROW_W + 2*i +: 2], sig[i]);
      end
      assign term[t] = &lit;
   end

endmodule

// File: rtl/cla_or_plane.sv
module cla_or_plane #(
   parameter int N_TERM = 32,
   parameter int N_OUT  = 10
) (
   input  logic [N_TERM-1:0]       term,
   input  logic [N_OUT*N_TERM-1:0] conn,
   input  logic [N_OUT-1:0]        pol,
   output logic [N_OUT-1:0]        z
);
   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      logic sop;
      assign sop  = |(term & conn[k*N_TERM +: N_TERM]);
      assign z[k] = sop ^ ~pol[k];
   end

endmodule

// File: rtl/cfg_logic_array.sv
module cfg_logic_array #(
   parameter  int N_IN    = 12,
   parameter  int N_BIDIR = 10,
   parameter  int N_LTERM = 32,
   localparam int N_SIG   = N_IN + N_BIDIR,
   localparam int ROW_W   = 2 * N_SIG,
   localparam int N_ATERM = N_LTERM + N_BIDIR,
   localparam int N_ROWS  = N_ATERM + N_BIDIR + 1,
   localparam int AW      = $clog2(N_ROWS),
   localparam int DW      = cla_pkg::cla_max3(ROW_W, N_LTERM, N_BIDIR)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [DW-1:0]      cfg_wdata,
   input  logic [N_IN-1:0]    din,
   input  logic [N_BIDIR-1:0] pin_in,
   output logic [N_BIDIR-1:0] pin_out,
   output logic [N_BIDIR-1:0] pin_oe
);
   if (N_IN < 1 || N_BIDIR < 1 || N_LTERM < 1) begin : g_bad_size
      $error("cfg_logic_array: every plane needs at least one element");
   end

   logic [N_ATERM*ROW_W-1:0]   and_links;
   logic [N_BIDIR*N_LTERM-1:0] or_links;
   logic [N_BIDIR-1:0]         pol_bits;
   logic [N_SIG-1:0]           sig;
   logic [N_LTERM-1:0]         lterm;

   assign sig = {pin_in, din};

   cla_cfg_store #(
      .N_ATERM(N_ATERM), .N_LTERM(N_LTERM), .N_OUT(N_BIDIR),
      .ROW_W(ROW_W), .AW(AW), .DW(DW)
   ) u_store (
      .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .and_links(and_links), .or_links(or_links), .pol_bits(pol_bits)
   );

   cla_and_plane #(.N_TERM(N_LTERM), .N_SIG(N_SIG)) u_logic_and (
      .sig(sig),
      .links(and_links[N_LTERM*ROW_W-1:0]),
      .term(lterm)
   );

   cla_and_plane #(.N_TERM(N_BIDIR), .N_SIG(N_SIG)) u_ctrl_and (
      .sig(sig),
      .links(and_links[N_ATERM*ROW_W-1:N_LTERM*ROW_W]),
      .term(pin_oe)
   );

   cla_or_plane #(.N_TERM(N_LTERM), .N_OUT(N_BIDIR)) u_or (
      .term(lterm), .conn(or_links), .pol(pol_bits), .z(pin_out)
   );

endmodule

// File: rtl/cla_checker.sv
module cla_checker #(
   parameter  int N_IN    = 12,
   parameter  int N_BIDIR = 10,
   parameter  int N_LTERM = 32,
   localparam int N_SIG   = N_IN + N_BIDIR,
   localparam int ROW_W   = 2 * N_SIG,
   localparam int N_ATERM = N_LTERM + N_BIDIR,
   localparam int N_ROWS  = N_ATERM + N_BIDIR + 1,
   localparam int AW      = $clog2(N_ROWS),
   localparam int POL_ADDR = N_ATERM + N_BIDIR
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       cfg_we,
   input logic [AW-1:0]              cfg_addr,
   input logic [N_BIDIR-1:0]         pol_wdata,
   input logic [N_IN-1:0]            din,
   input logic [N_BIDIR-1:0]         pin_in,
   input logic [N_BIDIR-1:0]         pin_out,
   input logic [N_BIDIR-1:0]         pin_oe,
   input logic [N_ATERM*ROW_W-1:0]   and_links,
   input logic [N_BIDIR*N_LTERM-1:0] or_links,
   input logic [N_BIDIR-1:0]         pol_bits
);
   logic seen_write;

   always_ff @(posedge clk) begin
      if (rst) seen_write <= 1'b0;
      else if (cfg_we && int'(cfg_addr) < N_ROWS) seen_write <= 1'b1;
   end

   function automatic logic row_inhibits(input logic [ROW_W-1:0] r);
      for (int i = 0; i < N_SIG; i++)
         if (r[2*i] && r[2*i+1]) return 1'b1;
      return 1'b0;
   endfunction

   a_r1_virgin_idle: assert property (@(posedge clk) disable iff (rst)
      !seen_write |-> (pin_oe == '0 && pin_out == '0));

   a_r7_unmapped_keep: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && int'(cfg_addr) >= N_ROWS) |=>
         ($stable(and_links) && $stable(or_links) && $stable(pol_bits)));

   a_r9_pol_lands: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && int'(cfg_addr) == POL_ADDR) |=> (pol_bits == $past(pol_wdata)));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !cfg_we |=> (($stable(din) && $stable(pin_in)) -> ($stable(pin_out) && $stable(pin_oe))));

   for (genvar k = 0; k < N_BIDIR; k++) begin : g_pin
      a_r6_inhibit_off: assert property (@(posedge clk) disable iff (rst)
         row_inhibits(and_links[(N_LTERM+k)*ROW_W +: ROW_W]) |-> !pin_oe[k]);

      a_r4_empty_or: assert property (@(posedge clk) disable iff (rst)
         (or_links[k*N_LTERM +: N_LTERM] == '0) |-> (pin_out[k] == !pol_bits[k]));
   end

endmodule

bind cfg_logic_array cla_checker #(
   .N_IN(N_IN), .N_BIDIR(N_BIDIR), .N_LTERM(N_LTERM)
) u_chk (
   .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .pol_wdata(cfg_wdata[N_BIDIR-1:0]), .din(din), .pin_in(pin_in),
   .pin_out(pin_out), .pin_oe(pin_oe), .and_links(and_links),
   .or_links(or_links), .pol_bits(pol_bits)
);

// File: tb/sim_cfg_logic_array.sv
`timescale 1ns/1ps
module sim_cfg_logic_array;
   localparam int N_IN = 12, N_BIDIR = 10, N_LTERM = 32;
   localparam int N_SIG = 22, ROW_W = 44, N_ATERM = 42;
   localparam int OR_BASE = 42, POL_ADDR = 52, AW = 6, DW = 44;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic               rst = 1'b1;
   logic               cfg_we = 1'b0;
   logic [AW-1:0]      cfg_addr = '0;
   logic [DW-1:0]      cfg_wdata = '0;
   logic [N_IN-1:0]    din = '0;
   logic [N_BIDIR-1:0] ext_lvl = '0;
   logic [N_BIDIR-1:0] pad_lvl, pin_out, pin_oe;

   assign pad_lvl = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

   cfg_logic_array u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .din(din), .pin_in(pad_lvl), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   logic [ROW_W-1:0]   m_and [N_ATERM];
   logic [N_LTERM-1:0] m_or  [N_BIDIR];
   logic [N_BIDIR-1:0] m_pol;
   int checks = 0, fails = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic m_term(input logic [ROW_W-1:0] row, input logic [N_SIG-1:0] s);
      logic p = 1'b1;
      for (int i = 0; i < N_SIG; i++) begin
         case ({row[2*i+1], row[2*i]})
            2'b01: p = p & s[i];
            2'b10: p = p & ~s[i];
            2'b11: p = 1'b0;
            default: ;
         endcase
      end
      return p;
   endfunction

   function automatic void m_eval(input logic [N_IN-1:0] d, input logic [N_BIDIR-1:0] e,
                                  output logic [N_BIDIR-1:0] o, output logic [N_BIDIR-1:0] en);
      logic [N_BIDIR-1:0] pad = e;
      o = '0; en = '0;
      for (int it = 0; it < N_BIDIR + 2; it++) begin
         for (int k = 0; k < N_BIDIR; k++) begin
            logic sop = 1'b0;
            for (int t = 0; t < N_LTERM; t++)
               if (m_or[k][t] && m_term(m_and[t], {pad, d})) sop = 1'b1;
            o[k]  = m_pol[k] ? sop : ~sop;
            en[k] = m_term(m_and[N_LTERM+k], {pad, d});
         end
         pad = (en & o) | (~en & e);
      end
   endfunction

   function automatic logic [ROW_W-1:0] pair(input int idx, input logic [1:0] code);
      logic [ROW_W-1:0] r = '0;
      r[2*idx +: 2] = code;
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cfg_we = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int r = 0; r < N_ATERM; r++) m_and[r] = '1;
      for (int k = 0; k < N_BIDIR; k++) m_or[k] = '1;
      m_pol = '1;
   endtask

   task automatic wr(input int addr, input logic [DW-1:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr < N_ATERM) m_and[addr] = data[ROW_W-1:0];
      else if (addr < OR_BASE + N_BIDIR) m_or[addr-OR_BASE] = data[N_LTERM-1:0];
      else if (addr == POL_ADDR) m_pol = data[N_BIDIR-1:0];
   endtask

   task automatic apply(input logic [N_IN-1:0] d, input logic [N_BIDIR-1:0] e);
      @(negedge clk);
      din = d; ext_lvl = e;
      #1;
   endtask

   task automatic cmp_model(input string req);
      logic [N_BIDIR-1:0] o, en;
      m_eval(din, ext_lvl, o, en);
      check(req, {12'h0, pin_oe, pin_out}, {12'h0, en, o});
   endtask

   function automatic logic [ROW_W-1:0] rand_row(input int n_used);
      logic [ROW_W-1:0] r = '0;
      for (int i = 0; i < n_used; i++) begin
         int v = int'($urandom % 10);
         if (v == 0) r[2*i +: 2] = 2'b01;
         else if (v == 1) r[2*i +: 2] = 2'b10;
         else if (v == 2 && ($urandom % 8) == 0) r[2*i +: 2] = 2'b11;
      end
      return r;
   endfunction

   task automatic t_reset();
      do_reset();
      for (int v = 0; v < 4; v++) begin
         apply(N_IN'($urandom), N_BIDIR'($urandom));
         check("R1 idle after reset", {12'h0, pin_oe, pin_out}, 32'h0);
      end
   endtask

   task automatic t_links();
      do_reset();
      wr(0, DW'(pair(0, 2'b01)));
      for (int b = 0; b < 2; b++) begin
         apply(N_IN'(b), '0);
         check("R2 true link", 32'(pin_out[0]), 32'(b));
         cmp_model("R2 true link model");
      end
      wr(0, DW'(pair(0, 2'b10)));
      for (int b = 0; b < 2; b++) begin
         apply(N_IN'(b), '0);
         check("R2 complement link", 32'(pin_out[0]), 32'(1 - b));
      end
      wr(0, '0);
      apply(12'h5a3, 10'h155);
      check("R2 all dont-care", 32'(pin_out), 32'h3ff);
      wr(0, DW'(pair(1, 2'b11)));
      apply(12'h002, '0);
      check("R2 inhibit with input high", 32'(pin_out), 32'h0);
      apply(12'h000, '0);
      check("R2 inhibit with input low", 32'(pin_out), 32'h0);
   endtask

   task automatic t_pins();
      do_reset();
      wr(1, DW'(pair(12 + 4, 2'b01)));
      wr(OR_BASE + 0, 32'h2);
      apply('0, 10'h010);
      check("R3 pad level 4 high", 32'(pin_out[0]), 32'h1);
      apply('0, 10'h000);
      check("R3 pad level 4 low", 32'(pin_out[0]), 32'h0);
      wr(N_LTERM + 7, '0);
      wr(2, DW'(pair(3, 2'b01)));
      wr(OR_BASE + 7, 32'h4);
      wr(3, DW'(pair(12 + 7, 2'b01)));
      wr(OR_BASE + 1, 32'h8);
      apply(12'h008, 10'h000);
      check("R3 driven pin feeds back", 32'(pin_out[1]), 32'h1);
      apply(12'h000, 10'h080);
      check("R3 driven pin overrides pad", 32'(pin_out[1]), 32'h0);
      cmp_model("R3 feedback model");
   endtask

   task automatic t_or();
      do_reset();
      wr(0, DW'(pair(0, 2'b01)));
      wr(1, DW'(pair(1, 2'b01)));
      wr(2, '0);
      wr(OR_BASE + 5, 32'h3);
      for (int v = 0; v < 4; v++) begin
         apply(N_IN'(v), '0);
         check("R4 or of connected terms", 32'(pin_out[5]), 32'((v != 0) ? 1 : 0));
      end
   endtask

   task automatic t_pol();
      do_reset();
      wr(0, DW'(pair(2, 2'b01)));
      wr(OR_BASE + 6, 32'h1);
      wr(POL_ADDR, DW'(10'h3bf));
      for (int b = 0; b < 2; b++) begin
         apply(N_IN'(b << 2), '0);
         check("R5 active-low output", 32'(pin_out[6]), 32'(1 - b));
         cmp_model("R5 polarity model");
      end
   endtask

   task automatic t_ctrl();
      do_reset();
      wr(N_LTERM + 2, DW'(pair(5, 2'b01)));
      apply(12'h020, 10'h3ff);
      check("R6 control term high", 32'(pin_oe), 32'h004);
      check("R6 driven pad level", 32'(pad_lvl), 32'h3fb);
      apply(12'h000, 10'h3ff);
      check("R6 control term low", 32'(pin_oe), 32'h000);
   endtask

   task automatic t_write();
      do_reset();
      apply('0, '0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(POL_ADDR); cfg_wdata = '0;
      #1;
      check("R9 before capture edge", 32'(pin_out), 32'h000);
      @(negedge clk);
      cfg_we = 1'b0; m_pol = '0;
      #1;
      check("R9 after capture edge", 32'(pin_out), 32'h3ff);
      wr(60, '0);
      wr(53, '0);
      #1;
      check("R7 unmapped write ignored", 32'(pin_out), 32'h3ff);
      cmp_model("R7 unmapped model");
      @(negedge clk);
      cfg_addr = AW'(POL_ADDR); cfg_wdata = '1;
      @(negedge clk);
      #1;
      check("R7 write without enable ignored", 32'(pin_out), 32'h3ff);
   endtask

   task automatic t_comb();
      do_reset();
      wr(0, DW'(pair(0, 2'b01)));
      apply(12'h001, '0);
      check("R8 output follows input", 32'(pin_out), 32'h3ff);
      din = 12'h000;
      #0.5;
      check("R8 change between edges", 32'(pin_out), 32'h000);
   endtask

   task automatic t_rand_out();
      for (int c = 0; c < 4; c++) begin
         do_reset();
         for (int k = 0; k < N_BIDIR; k++) wr(N_LTERM + k, '0);
         for (int t = 0; t < N_LTERM; t++) wr(t, DW'(rand_row(N_IN)));
         for (int k = 0; k < N_BIDIR; k++) wr(OR_BASE + k, DW'($urandom));
         wr(POL_ADDR, DW'(N_BIDIR'($urandom)));
         for (int v = 0; v < 16; v++) begin
            apply(N_IN'($urandom), N_BIDIR'($urandom));
            cmp_model("R4 R5 random all-output");
         end
      end
   endtask

   task automatic t_rand_mixed();
      for (int c = 0; c < 4; c++) begin
         do_reset();
         for (int k = 5; k < N_BIDIR; k++) wr(N_LTERM + k, DW'(rand_row(N_IN)));
         for (int t = 0; t < N_LTERM; t++) wr(t, DW'(rand_row(N_IN + 5)));
         for (int k = 0; k < N_BIDIR; k++) wr(OR_BASE + k, DW'($urandom));
         wr(POL_ADDR, DW'(N_BIDIR'($urandom)));
         for (int v = 0; v < 16; v++) begin
            apply(N_IN'($urandom), N_BIDIR'($urandom));
            cmp_model("R3 R6 random mixed direction");
         end
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      t_reset();
      t_links();
      t_pins();
      t_or();
      t_pol();
      t_ctrl();
      t_write();
      t_comb();
      t_rand_out();
      t_rand_mixed();
      finish_run();
   end

endmodule